// File: doc/BRIEF.md
# Shifter Operand Unit

This block forms the second operand of an integer ALU together with the carry produced while forming it. The operand comes from one of two sources. The first is a register value passed through a barrel shifter: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate that pulls the incoming carry flag into the top bit. The second is an 8-bit constant rotated right by an even amount.

The shift amount is either a 5-bit field taken from the instruction or the low byte of a register. The two sources follow different rules. An immediate field of zero stands for a 32-bit shift on the right shifts and selects the rotate-through-carry on rotate. A register amount is used as given, from 0 to 255. The shift kind code is 2'b00 for logical left, 2'b01 for logical right, 2'b10 for arithmetic right and 2'b11 for rotate right. Both outputs are registered, so a result appears one clock after its inputs. Instruction decoding and storage of the flags belong to the surrounding pipeline.

Top module: `shift_operand_unit`

## Requirements
- R1: A synchronous active-high reset clears `operand` and `carry_out` to zero. Outside reset, both outputs show the result for the inputs present at the previous rising clock edge.
- R2: With an immediate amount (`use_reg_amt`=0, `use_imm8`=0) and kind 2'b00, the value is shifted left by `imm_amt` (0 to 31). An amount of 0 returns the value unchanged and returns `carry_in` as the carry.
- R3: With an immediate amount and kind 2'b01 or 2'b10, a field of 1 to 31 shifts right by that amount and a field of 0 shifts right by 32. A 32-bit logical shift gives 0 with carry equal to bit 31. A 32-bit arithmetic shift gives bit 31 copied into every bit, with carry equal to bit 31.
- R4: With an immediate amount and kind 2'b11, a field of 1 to 31 rotates right by that amount. A field of 0 gives {`carry_in`, value[31:1]} with carry equal to value bit 0.
- R5: With a register amount (`use_reg_amt`=1), the 8-bit `reg_amt` gives the shift count for all four kinds. A count of 0 returns the value unchanged and returns `carry_in` as the carry.
- R6: For every nonzero shift, the carry is the last bit shifted out: bit 32-n for a left shift by n, and bit n-1 for a right shift or rotate by n.
- R7: With a register count of 32 or more, logical left and logical right shifts give 0. At exactly 32 the carry is bit 0 for left and bit 31 for right. Above 32 the carry is 0.
- R8: With a register count of 32 or more, an arithmetic right shift gives bit 31 copied into every bit, with carry equal to bit 31.
- R9: With a register count, rotate right uses the count modulo 32. A nonzero count that is a multiple of 32 returns the value unchanged, with carry equal to bit 31.
- R10: With `use_imm8`=1, the operand is `imm8` zero-extended and rotated right by twice `imm_rot`, and all shifter inputs are ignored. The carry is `carry_in` when `imm_rot` is 0 and bit 31 of the operand otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| use_reg_amt | input | 1 | 1 takes the amount from `reg_amt`, 0 from `imm_amt` |
| imm_amt | input | 5 | Immediate shift field |
| reg_amt | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| use_imm8 | input | 1 | 1 selects the rotated 8-bit constant path |
| imm8 | input | 8 | 8-bit constant |
| imm_rot | input | 4 | Rotate field; the constant is rotated right by twice this value |
| operand | output | 32 | Registered ALU operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The properties compare each output with the inputs from the previous cycle using $past. They therefore assume every input holds a known value at every clock edge, including the edges during reset. The bench drives all inputs to defined values before the first edge and changes them only on falling edges. Every pattern is a legal combination of kind, amount source and amount, so the register path sees counts from 0 up to 255. Long runs of random patterns sit alongside directed patterns at the counts where the rules change: 0, 1, 31, 32, 33 and large multiples of 32.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/sop_amount_dec.sv
// Turns the immediate field or register byte into an effective count.
module sop_amount_dec #(
  parameter int W         = 32,
  parameter int AMT_BITS  = 5,
  parameter int RAMT_BITS = 8
) (
  input  logic [1:0]           kind,
  input  logic                 use_reg,
  input  logic [AMT_BITS-1:0]  imm_amt,
  input  logic [RAMT_BITS-1:0] reg_amt,
  output logic [RAMT_BITS-1:0] amt,
  output logic                 rrx
);
  import sop_pkg::*;

  localparam logic [RAMT_BITS-1:0] FULL = RAMT_BITS'(W);

  shift_kind_e k;
  assign k = shift_kind_e'(kind);

  always_comb begin
    amt = '0;
    rrx = 1'b0;
    if (use_reg) begin
      amt = reg_amt;
    end else begin
      unique case (k)
        SK_LSL: amt = RAMT_BITS'(imm_amt);
        SK_LSR,
        SK_ASR: amt = (imm_amt == '0) ? FULL : RAMT_BITS'(imm_amt);
        default: begin
          if (imm_amt == '0) rrx = 1'b1;
          else               amt = RAMT_BITS'(imm_amt);
        end
      endcase
    end
  end
endmodule

// File: rtl/sop_barrel.sv
// Barrel shifter with carry; the operand is widened by one bit so the
// last bit shifted out lands in the extra position.
module sop_barrel #(
  parameter int W         = 32,
  parameter int AMT_BITS  = 5,
  parameter int RAMT_BITS = 8
) (
  input  logic [W-1:0]         value,
  input  logic [1:0]           kind,
  input  logic [RAMT_BITS-1:0] amt,
  input  logic                 rrx,
  input  logic                 cin,
  output logic [W-1:0]         res,
  output logic                 cout
);
  import sop_pkg::*;

  logic [W:0]          lsl_x;
  logic [W:0]          lsr_x;
  logic [W:0]          asr_x;
  logic [W-1:0]        ror_v;
  logic [AMT_BITS-1:0] rot;
  shift_kind_e         k;

  assign k     = shift_kind_e'(kind);
  assign lsl_x = {1'b0, value} << amt;
  assign lsr_x = {value, 1'b0} >> amt;
  assign asr_x = $signed({value, 1'b0}) >>> amt;
  assign rot   = amt[AMT_BITS-1:0];
  assign ror_v = (value >> rot) | (value << (W - int'(rot)));

  always_comb begin
    res  = value;
    cout = cin;
    if (rrx) begin
      res  = {cin, value[W-1:1]};
      cout = value[0];
    end else if (amt != '0) begin
      unique case (k)
        SK_LSL: {cout, res} = lsl_x;
        SK_LSR: {res, cout} = lsr_x;
        SK_ASR: {res, cout} = asr_x;
        default: begin
          res  = ror_v;
          cout = ror_v[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/sop_imm_rot.sv
// Forms an operand from a small constant rotated right by an even count.
module sop_imm_rot #(
  parameter int W        = 32,
  parameter int IMM_BITS = 8,
  parameter int ROT_BITS = 4
) (
  input  logic [IMM_BITS-1:0] imm,
  input  logic [ROT_BITS-1:0] rot,
  input  logic                cin,
  output logic [W-1:0]        res,
  output logic                cout
);
  localparam int RB = ROT_BITS + 1;

  logic [W-1:0]  base;
  logic [RB-1:0] r;

  assign base = W'(imm);
  assign r    = {rot, 1'b0};
  assign res  = (base >> r) | (base << (W - int'(r)));
  assign cout = (rot == '0) ? cin : res[W-1];
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit #(
  parameter int W         = 32,
  parameter int RAMT_BITS = 8,
  parameter int IMM_BITS  = 8,
  parameter int ROT_BITS  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         src_val,
  input  logic [1:0]           shift_kind,
  input  logic                 use_reg_amt,
  input  logic [$clog2(W)-1:0] imm_amt,
  input  logic [RAMT_BITS-1:0] reg_amt,
  input  logic                 carry_in,
  input  logic                 use_imm8,
  input  logic [IMM_BITS-1:0]  imm8,
  input  logic [ROT_BITS-1:0]  imm_rot,
  output logic [W-1:0]         operand,
  output logic                 carry_out
);
  localparam int AMT_BITS = $clog2(W);

  logic [RAMT_BITS-1:0] eff_amt;
  logic                 eff_rrx;
  logic [W-1:0]         sh_res;
  logic                 sh_c;
  logic [W-1:0]         im_res;
  logic                 im_c;

  sop_amount_dec #(.W(W), .AMT_BITS(AMT_BITS), .RAMT_BITS(RAMT_BITS)) u_dec (
    .kind    (shift_kind),
    .use_reg (use_reg_amt),
    .imm_amt (imm_amt),
    .reg_amt (reg_amt),
    .amt     (eff_amt),
    .rrx     (eff_rrx)
  );

  sop_barrel #(.W(W), .AMT_BITS(AMT_BITS), .RAMT_BITS(RAMT_BITS)) u_sh (
    .value (src_val),
    .kind  (shift_kind),
    .amt   (eff_amt),
    .rrx   (eff_rrx),
    .cin   (carry_in),
    .res   (sh_res),
    .cout  (sh_c)
  );

  sop_imm_rot #(.W(W), .IMM_BITS(IMM_BITS), .ROT_BITS(ROT_BITS)) u_im (
    .imm  (imm8),
    .rot  (imm_rot),
    .cin  (carry_in),
    .res  (im_res),
    .cout (im_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand   <= '0;
      carry_out <= 1'b0;
    end else begin
      operand   <= use_imm8 ? im_res : sh_res;
      carry_out <= use_imm8 ? im_c   : sh_c;
    end
  end
endmodule

// File: rtl/sop_chk.sv
module sop_chk #(
  parameter int W         = 32,
  parameter int RAMT_BITS = 8,
  parameter int IMM_BITS  = 8,
  parameter int ROT_BITS  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         src_val,
  input logic [1:0]           shift_kind,
  input logic                 use_reg_amt,
  input logic [$clog2(W)-1:0] imm_amt,
  input logic [RAMT_BITS-1:0] reg_amt,
  input logic                 carry_in,
  input logic                 use_imm8,
  input logic [IMM_BITS-1:0]  imm8,
  input logic [ROT_BITS-1:0]  imm_rot,
  input logic [W-1:0]         operand,
  input logic                 carry_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (operand == '0 && carry_out == 1'b0));

  // R5
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!use_imm8 && use_reg_amt && reg_amt == '0))
    |-> (operand == $past(src_val) && carry_out == $past(carry_in)));

  // R4
  rrx_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!use_imm8 && !use_reg_amt && shift_kind == 2'b11 && imm_amt == '0))
    |-> (operand == {$past(carry_in), $past(src_val[W-1:1])}
         && carry_out == $past(src_val[0])));

  // R3
  lsr_imm_full_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!use_imm8 && !use_reg_amt && shift_kind == 2'b01 && imm_amt == '0))
    |-> (operand == '0 && carry_out == $past(src_val[W-1])));

  // R7
  lsx_large_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!use_imm8 && use_reg_amt && !shift_kind[1] && int'(reg_amt) > W))
    |-> (operand == '0 && carry_out == 1'b0));

  // R8
  asr_large_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!use_imm8 && use_reg_amt && shift_kind == 2'b10 && int'(reg_amt) >= W))
    |-> (operand == {W{$past(src_val[W-1])}} && carry_out == $past(src_val[W-1])));

  // R10
  imm_norot_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(use_imm8 && imm_rot == '0))
    |-> (operand == W'($past(imm8)) && carry_out == $past(carry_in)));
endmodule

bind shift_operand_unit sop_chk #(
  .W(W), .RAMT_BITS(RAMT_BITS), .IMM_BITS(IMM_BITS), .ROT_BITS(ROT_BITS)
) u_chk (.*);

// File: tb/sim_shift_operand_unit.sv
`timescale 1ns/1ps
module sim_shift_operand_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        use_reg_amt = 1'b0;
  logic [4:0]  imm_amt = '0;
  logic [7:0]  reg_amt = '0;
  logic        carry_in = 1'b0;
  logic        use_imm8 = 1'b0;
  logic [7:0]  imm8 = '0;
  logic [3:0]  imm_rot = '0;
  logic [31:0] operand;
  logic        carry_out;

  typedef struct {
    logic [31:0] op;
    logic        c;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  always #5 clk = ~clk;

  shift_operand_unit u0 (.*);

  // Reference: one bit position per step, following the requirements.
  function automatic void model(input logic [31:0] v_in, input logic [1:0] k,
      input logic ur, input logic [4:0] ia, input logic [7:0] ra,
      input logic ci, input logic ui, input logic [7:0] i8, input logic [3:0] ir,
      output logic [31:0] vo, output logic co);
    logic [31:0] v;
    logic        c;
    int          n;
    v = v_in;
    c = ci;
    if (ui) begin
      v = {24'd0, i8};
      for (int i = 0; i < 2 * int'(ir); i++) v = {v[0], v[31:1]};
      if (ir != 0) c = v[31];
    end else if (!ur && k == 2'b11 && ia == 0) begin
      c = v[0];
      v = {ci, v[31:1]};
    end else begin
      if (ur) n = int'(ra);
      else if ((k == 2'b01 || k == 2'b10) && ia == 0) n = 32;
      else n = int'(ia);
      for (int i = 0; i < n; i++) begin
        case (k)
          2'b00: begin c = v[31]; v = v << 1; end
          2'b01: begin c = v[0]; v = v >> 1; end
          2'b10: begin c = v[0]; v = {v[31], v[31:1]}; end
          default: begin c = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    vo = v;
    co = c;
  endfunction

  task automatic drive(input logic [31:0] v, input logic [1:0] k, input logic ur,
      input logic [4:0] ia, input logic [7:0] ra, input logic ci, input logic ui,
      input logic [7:0] i8, input logic [3:0] ir, input string tag);
    exp_t e;
    @(negedge clk);
    src_val = v; shift_kind = k; use_reg_amt = ur; imm_amt = ia; reg_amt = ra;
    carry_in = ci; use_imm8 = ui; imm8 = i8; imm_rot = ir;
    model(v, k, ur, ia, ra, ci, ui, i8, ir, e.op, e.c);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: one result per clock, one cycle after its inputs.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (operand !== e.op || carry_out !== e.c) begin
          fails++;
          $display("FAIL %s: actual operand=%h carry=%b expected operand=%h carry=%b",
                   e.tag, operand, carry_out, e.op, e.c);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_test();
    end
  end

  initial begin
    // R1: reset holds outputs at zero while the inputs are busy
    src_val = 32'hFFFF_FFFF; carry_in = 1'b1; imm_amt = 5'd3;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (operand !== 32'd0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: actual operand=%h carry=%b expected operand=00000000 carry=0",
               operand, carry_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: immediate left shift
    drive(32'h1234_5678, 2'b00, 0, 5'd0,  8'd0, 1, 0, 8'd0, 4'd0, "R2 lsl #0");
    drive(32'hF000_000F, 2'b00, 0, 5'd4,  8'd0, 0, 0, 8'd0, 4'd0, "R2 lsl #4");
    drive(32'h0000_0003, 2'b00, 0, 5'd31, 8'd0, 0, 0, 8'd0, 4'd0, "R2 lsl #31");
    // R3: immediate right shifts, zero field means 32
    drive(32'h8000_0001, 2'b01, 0, 5'd0,  8'd0, 0, 0, 8'd0, 4'd0, "R3 lsr #32");
    drive(32'h8000_0000, 2'b10, 0, 5'd0,  8'd0, 0, 0, 8'd0, 4'd0, "R3 asr #32");
    drive(32'h7FFF_FFFF, 2'b10, 0, 5'd0,  8'd0, 1, 0, 8'd0, 4'd0, "R3 asr #32 pos");
    drive(32'h0000_0003, 2'b01, 0, 5'd1,  8'd0, 0, 0, 8'd0, 4'd0, "R3 lsr #1");
    // R4: rotate and rotate-through-carry
    drive(32'h0000_0003, 2'b11, 0, 5'd0,  8'd0, 1, 0, 8'd0, 4'd0, "R4 rrx cin1");
    drive(32'h0000_0002, 2'b11, 0, 5'd0,  8'd0, 0, 0, 8'd0, 4'd0, "R4 rrx cin0");
    drive(32'h0000_0080, 2'b11, 0, 5'd8,  8'd0, 0, 0, 8'd0, 4'd0, "R4 ror #8");
    // R5: register count of zero for all kinds
    for (int kk = 0; kk < 4; kk++) begin
      drive(32'hA5A5_5A5A, 2'(kk), 1, 5'd0, 8'd0, 1, 0, 8'd0, 4'd0, "R5 reg 0 c1");
      drive(32'h0F0F_F0F0, 2'(kk), 1, 5'd7, 8'd0, 0, 0, 8'd0, 4'd0, "R5 reg 0 c0");
    end
    // R7: large logical shifts
    drive(32'h0000_0001, 2'b00, 1, 5'd0, 8'd32,  0, 0, 8'd0, 4'd0, "R7 lsl 32");
    drive(32'hFFFF_FFFF, 2'b00, 1, 5'd0, 8'd33,  1, 0, 8'd0, 4'd0, "R7 lsl 33");
    drive(32'h8000_0000, 2'b01, 1, 5'd0, 8'd32,  0, 0, 8'd0, 4'd0, "R7 lsr 32");
    drive(32'hFFFF_FFFF, 2'b01, 1, 5'd0, 8'd200, 1, 0, 8'd0, 4'd0, "R7 lsr 200");
    // R8: large arithmetic shifts
    drive(32'h8000_0000, 2'b10, 1, 5'd0, 8'd40,  0, 0, 8'd0, 4'd0, "R8 asr 40 neg");
    drive(32'h7FFF_FFFF, 2'b10, 1, 5'd0, 8'd255, 1, 0, 8'd0, 4'd0, "R8 asr 255 pos");
    // R9: register rotate modulo 32
    drive(32'h8000_0000, 2'b11, 1, 5'd0, 8'd32,  0, 0, 8'd0, 4'd0, "R9 ror 32");
    drive(32'h1234_5678, 2'b11, 1, 5'd0, 8'd36,  0, 0, 8'd0, 4'd0, "R9 ror 36");
    drive(32'h0000_0001, 2'b11, 1, 5'd0, 8'd224, 0, 0, 8'd0, 4'd0, "R9 ror 224");
    // R10: rotated constant, shifter inputs ignored
    drive(32'hFFFF_FFFF, 2'b10, 1, 5'd3, 8'd40, 1, 1, 8'hFF, 4'd0,  "R10 rot 0");
    drive(32'hFFFF_FFFF, 2'b00, 0, 5'd9, 8'd1,  0, 1, 8'h03, 4'd1,  "R10 rot 2");
    drive(32'h0000_0000, 2'b11, 0, 5'd0, 8'd0,  1, 1, 8'h81, 4'd15, "R10 rot 30");
    drive(32'h1111_1111, 2'b01, 1, 5'd1, 8'd2,  1, 1, 8'h40, 4'd4,  "R10 rot 8");
    // R6: carry is the last bit out, across random patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      logic [7:0]  ra;
      rv = $urandom;
      ra = (i % 3 == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom);
      drive(rv, 2'($urandom), 1'($urandom), 5'($urandom), ra, 1'($urandom),
            (i % 5 == 0), 8'($urandom), 4'($urandom), "R6 random");
    end
    repeat (4) @(posedge clk);
    done = 1;
    finish_test();
  end
endmodule